// File: doc/BRIEF.md
# CPU core power-up sequencer

This block brings one processor core out of its powered-off state. A one-cycle start pulse launches a fixed series of steps on an 8-bit power-control word. The steps apply clamps, turn on a global head switch with a settling count, release the memory clamp, enable the memory head switch, release the logic clamp, and then release both core resets together. The last step raises a powered-up flag and a done indication. The machine then holds that final pattern until the next start.

Three of the steps are followed by a timed wait. The length of each wait is set by a clock-frequency parameter in cycles per microsecond, so the same RTL can be used at any clock rate. Each output register changes only when the sequencer moves to a new step, so the clamp and reset lines never see a glitch.

Top module: `core_pwrup_seq`

## Requirements
- R1: While rst_n is low, and in idle after reset, ctrl_o, hs_en_o, hs_cnt_o and done_o are all zero.
- R2: One cycle after a start is sampled in idle or done, ctrl_o is 0x33. This sets bit 0 (logic clamp), bit 1 (memory clamp), bit 4 (core reset) and bit 5 (power-on reset). hs_en_o and done_o are 0, and the pattern lasts exactly one cycle.
- R3: In the next step hs_en_o becomes 1 with hs_cnt_o equal to HS_COUNT (16). ctrl_o stays 0x33 for the wait, and hs_en_o and hs_cnt_o keep these values through done.
- R4: The memory clamp is released first (ctrl_o 0x31, for one cycle). Then bit 3 (memory head switch) is set, giving 0x39, which is held for the wait.
- R5: Next the logic clamp (bit 0) is released, giving 0x38, which is held for the wait.
- R6: Core reset and power-on reset clear in the same cycle (ctrl_o 0x08, for one cycle). Only in the following cycle is bit 7 (powered-up) set, giving 0x88 with done_o high.
- R7: done_o and ctrl_o 0x88 are held for as long as no start arrives. A start in done restarts the sequence at R2.
- R8: A start pulse sampled while the sequence is in progress has no effect on the step order or the timing.
- R9: Bit 2 (L1 reset disable) and bit 6 (clock gate) of ctrl_o are always 0.
- R10: Each wait step lasts exactly WAIT_US * CYC_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse, sampled on the rising clock edge |
| ctrl_o | output | 8 | Core power-control word (bit map in R2 to R6, R9) |
| hs_en_o | output | 1 | Global head-switch enable |
| hs_cnt_o | output | HS_CNT_W (8) | Head-switch settling count, HS_COUNT while enabled |
| done_o | output | 1 | Sequence complete, core powered up |

## Verification
The bench walks the full sequence and checks the last cycle and the first cycle of every wait. A timer that is off by one cycle, or a wait taken at the wrong step, therefore appears as a wrong control word at one of those sample points. Start pulses are injected in the middle of the head-switch wait and the memory head-switch wait. A machine that reacts to a start while busy would jump back to 0x33 and shift every later step. The bench also restarts from done and checks that done drops and the 0x33 pattern returns. An asynchronous reset is applied in the middle of a sequence. A design whose output registers stay outside the reset would leave clamp or reset bits set after it.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAMP_ALL,
    ST_GHS_WAIT,
    ST_MCLAMP_OFF,
    ST_MEMHS_WAIT,
    ST_LCLAMP_WAIT,
    ST_RST_OFF,
    ST_DONE
  } seq_state_e;

  localparam int unsigned CTRL_W     = 8;
  localparam int unsigned B_LCLAMP   = 0;
  localparam int unsigned B_MCLAMP   = 1;
  localparam int unsigned B_L1RSTDIS = 2;
  localparam int unsigned B_MEMHS    = 3;
  localparam int unsigned B_CRST     = 4;
  localparam int unsigned B_PORST    = 5;
  localparam int unsigned B_CLKGATE  = 6;
  localparam int unsigned B_PWRUP    = 7;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic              hs_en;
    logic              done;
  } seq_out_t;

  function automatic logic is_wait(seq_state_e s);
    return (s == ST_GHS_WAIT) || (s == ST_MEMHS_WAIT) || (s == ST_LCLAMP_WAIT);
  endfunction

  function automatic seq_out_t decode_state(seq_state_e s);
    seq_out_t o;
    o = '0;
    case (s)
      ST_CLAMP_ALL: begin
        o.ctrl[B_LCLAMP] = 1'b1;
        o.ctrl[B_MCLAMP] = 1'b1;
        o.ctrl[B_CRST]   = 1'b1;
        o.ctrl[B_PORST]  = 1'b1;
      end
      ST_GHS_WAIT: begin
        o.ctrl[B_LCLAMP] = 1'b1;
        o.ctrl[B_MCLAMP] = 1'b1;
        o.ctrl[B_CRST]   = 1'b1;
        o.ctrl[B_PORST]  = 1'b1;
        o.hs_en          = 1'b1;
      end
      ST_MCLAMP_OFF: begin
        o.ctrl[B_LCLAMP] = 1'b1;
        o.ctrl[B_CRST]   = 1'b1;
        o.ctrl[B_PORST]  = 1'b1;
        o.hs_en          = 1'b1;
      end
      ST_MEMHS_WAIT: begin
        o.ctrl[B_LCLAMP] = 1'b1;
        o.ctrl[B_MEMHS]  = 1'b1;
        o.ctrl[B_CRST]   = 1'b1;
        o.ctrl[B_PORST]  = 1'b1;
        o.hs_en          = 1'b1;
      end
      ST_LCLAMP_WAIT: begin
        o.ctrl[B_MEMHS]  = 1'b1;
        o.ctrl[B_CRST]   = 1'b1;
        o.ctrl[B_PORST]  = 1'b1;
        o.hs_en          = 1'b1;
      end
      ST_RST_OFF: begin
        o.ctrl[B_MEMHS]  = 1'b1;
        o.hs_en          = 1'b1;
      end
      ST_DONE: begin
        o.ctrl[B_MEMHS]  = 1'b1;
        o.ctrl[B_PWRUP]  = 1'b1;
        o.hs_en          = 1'b1;
        o.done           = 1'b1;
      end
      default: o = '0;
    endcase
    // Bits that this sequence never drives stay low in every step.
    o.ctrl[B_L1RSTDIS] = 1'b0;
    o.ctrl[B_CLKGATE]  = 1'b0;
    return o;
  endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
  parameter int unsigned WAIT_CYC = 500,
  localparam int unsigned CNT_W   = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       expired_i,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       load_o
);

  logic state_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_CLAMP_ALL;
      ST_CLAMP_ALL:     state_d = ST_GHS_WAIT;
      ST_GHS_WAIT:      if (expired_i) state_d = ST_MCLAMP_OFF;
      ST_MCLAMP_OFF:    state_d = ST_MEMHS_WAIT;
      ST_MEMHS_WAIT:    if (expired_i) state_d = ST_LCLAMP_WAIT;
      ST_LCLAMP_WAIT:   if (expired_i) state_d = ST_RST_OFF;
      ST_RST_OFF:       state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);
  assign load_o   = state_en && is_wait(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/pwr_out_stage.sv
module pwr_out_stage
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  seq_out_t          nxt_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              hs_en_o,
  output logic              done_o
);

  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (upd_i) begin
        bit_q <= nxt_i.ctrl[b];
      end
    end
    assign ctrl_o[b] = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (upd_i) begin
      hs_en_o <= nxt_i.hs_en;
      done_o  <= nxt_i.done;
    end
  end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 250,
  parameter int unsigned WAIT_US    = 2,
  parameter int unsigned HS_CNT_W   = 8,
  parameter int unsigned HS_COUNT   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic [7:0]          ctrl_o,
  output logic                hs_en_o,
  output logic [HS_CNT_W-1:0] hs_cnt_o,
  output logic                done_o
);

  localparam int unsigned WAIT_CYC = CYC_PER_US * WAIT_US;
  localparam logic [HS_CNT_W-1:0] HS_VAL = HS_CNT_W'(HS_COUNT);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       load;
  logic       expired;
  seq_out_t   nxt_out;

  pwr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .expired_i (expired),
    .state_q   (state_q),
    .state_d   (state_d),
    .load_o    (load)
  );

  pwr_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .expired_o (expired)
  );

  assign nxt_out = decode_state(state_d);

  pwr_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (state_d != state_q),
    .nxt_i   (nxt_out),
    .ctrl_o  (ctrl_o),
    .hs_en_o (hs_en_o),
    .done_o  (done_o)
  );

  assign hs_cnt_o = hs_en_o ? HS_VAL : '0;

endmodule

// File: rtl/core_pwrup_chk.sv
module core_pwrup_chk #(
  parameter int unsigned CYC_PER_US = 250,
  parameter int unsigned WAIT_US    = 2,
  parameter int unsigned HS_CNT_W   = 8,
  parameter int unsigned HS_COUNT   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [7:0]          ctrl_o,
  input logic                hs_en_o,
  input logic [HS_CNT_W-1:0] hs_cnt_o,
  input logic                done_o
);

  localparam int unsigned WAIT_CYC = CYC_PER_US * WAIT_US;

  logic [31:0] memhs_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memhs_run_q <= '0;
    end else if (ctrl_o == 8'h39) begin
      memhs_run_q <= memhs_run_q + 1'b1;
    end else begin
      memhs_run_q <= '0;
    end
  end

  // R9
  unused_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[2] && !ctrl_o[6]);

  // R6
  final_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctrl_o == 8'h88) && hs_en_o);

  // R6
  pwrup_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[7]) |-> !ctrl_o[4] && !ctrl_o[5] && $past(!ctrl_o[4] && !ctrl_o[5]));

  // R6
  resets_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_o[4]) |-> $fell(ctrl_o[5]));

  // R4
  memhs_after_mclamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[3]) |-> !ctrl_o[1] && $past(!ctrl_o[1]));

  // R5
  lclamp_after_memhs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_o[0]) |-> ctrl_o[3]);

  // R3
  hs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en_o |-> (hs_cnt_o == HS_CNT_W'(HS_COUNT)));

  // R10
  memhs_wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_o == 8'h38) && ($past(ctrl_o) == 8'h39)) |-> (memhs_run_q == WAIT_CYC));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && $stable(ctrl_o));

endmodule

bind core_pwrup_seq core_pwrup_chk #(
  .CYC_PER_US (CYC_PER_US),
  .WAIT_US    (WAIT_US),
  .HS_CNT_W   (HS_CNT_W),
  .HS_COUNT   (HS_COUNT)
) u_chk (.*);

// File: tb/sim_core_pwrup_seq.sv
`timescale 1ns/1ps
module sim_core_pwrup_seq;

  localparam int W    = 250 * 2;
  localparam int N    = 11;
  localparam int LAST = 3*W + 10;

  typedef struct packed {
    logic [15:0] k;
    logic [7:0]  ctrl;
    logic        hs;
    logic        done;
  } vec_t;

  localparam vec_t TBL [N] = '{
    '{16'(0),       8'h33, 1'b0, 1'b0},
    '{16'(1),       8'h33, 1'b1, 1'b0},
    '{16'(W),       8'h33, 1'b1, 1'b0},
    '{16'(W+1),     8'h31, 1'b1, 1'b0},
    '{16'(W+2),     8'h39, 1'b1, 1'b0},
    '{16'(2*W+1),   8'h39, 1'b1, 1'b0},
    '{16'(2*W+2),   8'h38, 1'b1, 1'b0},
    '{16'(3*W+1),   8'h38, 1'b1, 1'b0},
    '{16'(3*W+2),   8'h08, 1'b1, 1'b0},
    '{16'(3*W+3),   8'h88, 1'b1, 1'b1},
    '{16'(3*W+10),  8'h88, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] ctrl_o;
  logic       hs_en_o;
  logic [7:0] hs_cnt_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  core_pwrup_seq u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ctrl_o   (ctrl_o),
    .hs_en_o  (hs_en_o),
    .hs_cnt_o (hs_cnt_o),
    .done_o   (done_o)
  );

  function automatic string tag_of(int i);
    case (i)
      0:       return "R2";
      1:       return "R3";
      2:       return "R10";
      3, 4, 5: return "R4";
      6, 7:    return "R5";
      8, 9:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Start pulse, then walk the table; inject_k >= 0 drives an extra start mid-run.
  task automatic run_seq(int inject_k, string tag);
    int idx = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int k = 0; k <= LAST; k++) begin
      if (idx < N && int'(TBL[idx].k) == k) begin
        chk(tag_of(idx), {24'h0, ctrl_o}, {24'h0, TBL[idx].ctrl});
        chk(tag_of(idx), {31'h0, hs_en_o}, {31'h0, TBL[idx].hs});
        chk(tag_of(idx), {31'h0, done_o}, {31'h0, TBL[idx].done});
        chk("R3", {24'h0, hs_cnt_o}, TBL[idx].hs ? 32'd16 : 32'd0);
        chk("R9", {30'h0, ctrl_o[6], ctrl_o[2]}, 32'h0);
        if (inject_k >= 0) chk(tag, {24'h0, ctrl_o}, {24'h0, TBL[idx].ctrl});
        idx++;
      end
      start_i = (k == inject_k);
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1", {16'h0, ctrl_o, hs_cnt_o}, 32'h0);
    chk("R1", {30'h0, hs_en_o, done_o}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: idle stays cleared with no start
    chk("R1", {16'h0, ctrl_o, hs_cnt_o}, 32'h0);
    chk("R1", {30'h0, hs_en_o, done_o}, 32'h0);

    // Main walk from idle (R2..R6, R10)
    run_seq(-1, "R2");

    // R7: done and final pattern held with no start
    repeat (100) @(negedge clk);
    chk("R7", {23'h0, done_o, ctrl_o}, {23'h0, 1'b1, 8'h88});

    // R7: restart from done, with R8 start injected during head-switch wait
    run_seq(5, "R8");
    // R8: start injected during memory head-switch wait
    run_seq(2*W, "R8");
    // R8: start injected during logic-clamp wait, one cycle before release
    run_seq(3*W, "R8");

    // R1: asynchronous reset in the middle of a sequence
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (W + 5) @(negedge clk);
    chk("R4", {24'h0, ctrl_o}, 32'h39);
    rst_n = 1'b0;
    #1;
    chk("R1", {16'h0, ctrl_o, hs_cnt_o}, 32'h0);
    chk("R1", {30'h0, hs_en_o, done_o}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {24'h0, ctrl_o}, 32'h0);

    // Full sequence again after the reset
    run_seq(-1, "R2");
    finish_run();
  end

endmodule